// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits on the receive path of a 10/100 MAC. It watches the destination address bytes of an incoming frame as they arrive, one byte per accepted beat. From them it decides whether the frame is kept. A frame is kept when any of these holds: it is broadcast, it matches the station's own address, it is a multicast group address that software has opted into, or the filter is in promiscuous mode. Group opt-in is either blanket, through an all-groups enable, or selective, through a 64-bin hash table. The hash index is drawn from a CRC-32 computed over the destination address on the fly, so no second pass over the bytes is needed.

The outputs are a decision-valid strobe level and three flags: keep, broadcast and multicast. The receive status writer copies these into the status word it stores ahead of the frame. The decision is registered on the clock edge that takes the last destination byte. It then stays frozen until the next frame begins, so the later stages of the frame cannot disturb it.

Top module: `eaf_filter`

## Requirements
- R1: After reset, `dec_valid`, `keep`, `is_bcast` and `is_mcast` are all 0, and bytes presented without `sof` are ignored until a frame starts.
- R2: A frame starts when `byte_vld` and `sof` are both high; that byte is destination byte 0 and `dec_valid` drops to 0 on that edge. `dec_valid` becomes 1 on the edge that takes byte 5. From then on, `dec_valid`, `keep`, `is_bcast` and `is_mcast` stay constant until the next frame start.
- R3: A destination of all ones (every byte 0xFF) sets `is_bcast`=1 and `is_mcast`=0, and is kept.
- R4: Byte 0 is compared with `station_addr[47:40]`, byte 1 with `station_addr[39:32]`, and so on down to byte 5 with `station_addr[7:0]`. A destination equal in all six bytes is kept.
- R5: With `promisc`=0, a destination that is neither broadcast, nor a station match, nor an enabled multicast, gives `keep`=0.
- R6: A destination whose byte 0 has bit 0 set and which is not broadcast sets `is_mcast`=1. A destination with bit 0 of byte 0 clear sets `is_mcast`=0.
- R7: With `all_mcast`=1, any multicast destination is kept, whatever `hash_tbl` holds.
- R8: With `all_mcast`=0, a multicast destination is kept only if `hash_tbl[h]` is 1. The CRC uses polynomial 0xEDB88320 in reflected form. It starts from 0xFFFFFFFF, is fed the six bytes in arrival order with the least significant bit first, and is not complemented at the end. `h` is bits 31..26 of the resulting register. Bits 5..3 of `h` select the table byte `hash_tbl[8k+7:8k]`, and bits 2..0 select the bit within it.
- R9: With `promisc`=1, every destination is kept.
- R10: Bytes after byte 5 of a frame, and changes to `promisc`, `all_mcast`, `station_addr` and `hash_tbl` after the decision, do not change any output.
- R11: A frame start arriving before byte 5 of the previous frame abandons that frame. The new frame is judged on its own six bytes only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A destination byte is on `byte_in` this cycle |
| sof | input | 1 | Qualifies the current byte as byte 0 of a new frame |
| byte_in | input | 8 | Destination address byte |
| station_addr | input | 48 | Station individual address, byte 0 in bits 47:40 |
| hash_tbl | input | 64 | Multicast hash table, eight bytes of eight bins |
| promisc | input | 1 | Keep every frame |
| all_mcast | input | 1 | Keep every multicast frame |
| dec_valid | output | 1 | Decision for the current frame is available |
| keep | output | 1 | Frame is to be kept |
| is_bcast | output | 1 | Destination was the broadcast address |
| is_mcast | output | 1 | Destination was a non-broadcast group address |

## Verification
The bench builds the block with its defaults: a six-byte address and a six-bit hash, which gives a 64-bin table. With these values the full R8 mapping can be exercised. The bench computes each multicast address's bin independently and then loads tables that hold only that bin, or every bin except it. This separates a correct index from one taken from the wrong CRC bits or the wrong byte order. The six-byte depth also makes room for the cases of R10 and R11: a frame restarted after three bytes, and trailing bytes fed after the decision.

// File: rtl/eaf_pkg.sv
package eaf_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;

  // Advance a reflected CRC by one byte, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                input logic [7:0]       d);
    logic [CRC_W-1:0] c;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ CRC_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/eaf_crc.sv
module eaf_crc
  import eaf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             first,
  input  logic [7:0]       data,
  output logic [CRC_W-1:0] crc_upd
);
  logic [CRC_W-1:0] crc_q, crc_d, crc_base;

  always_comb begin
    crc_base = first ? CRC_SEED : crc_q;
    crc_upd  = crc_step(crc_base, data);
    crc_d    = crc_q;
    if (take) crc_d = crc_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

  // R10: the running CRC only moves on a taken address byte
  assert_crc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(crc_q));
endmodule

// File: rtl/eaf_addr_track.sv
module eaf_addr_track #(
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    byte_vld,
  input  logic                    sof,
  input  logic [7:0]              byte_in,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  output logic                    take,
  output logic                    first,
  output logic                    last,
  output logic                    match_upd,
  output logic                    ones_upd,
  output logic                    group_upd
);
  localparam int unsigned CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] FULL  = CW'(ADDR_BYTES);
  localparam logic [CW-1:0] FINAL = CW'(ADDR_BYTES - 1);

  logic [CW-1:0] cnt_q, cnt_d, base;
  logic          match_q, ones_q, group_q;
  logic          match_d, ones_d, group_d;
  logic [7:0]    stn_byte;

  always_comb begin
    stn_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (base == CW'(i)) stn_byte = station_addr[8*(ADDR_BYTES-1-i) +: 8];
  end

  always_comb begin
    base      = sof ? '0 : cnt_q;
    take      = byte_vld && (base < FULL);
    first     = (base == '0);
    last      = (base == FINAL);
    match_upd = (first | match_q) & (byte_in == stn_byte);
    ones_upd  = (first | ones_q) & (byte_in == 8'hFF);
    group_upd = first ? byte_in[0] : group_q;
    cnt_d   = cnt_q;
    match_d = match_q;
    ones_d  = ones_q;
    group_d = group_q;
    if (take) begin
      cnt_d   = base + 1'b1;
      match_d = match_upd;
      ones_d  = ones_upd;
      group_d = group_upd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= FULL;
      match_q <= 1'b0;
      ones_q  <= 1'b0;
      group_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      match_q <= match_d;
      ones_q  <= ones_d;
      group_q <= group_d;
    end
  end

  // R10: the byte count saturates once the address is complete
  assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  // R11: a frame start always restarts counting at one byte taken
  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && sof) |=> (cnt_q == CW'(1)));
endmodule

// File: rtl/eaf_hash_lookup.sv
module eaf_hash_lookup
  import eaf_pkg::*;
#(
  parameter int unsigned HASH_BITS = 6
) (
  input  logic [CRC_W-1:0]          crc,
  input  logic [(1<<HASH_BITS)-1:0] table_bits,
  output logic                      hit
);
  localparam int unsigned SEL_BITS = (HASH_BITS > 3) ? HASH_BITS - 3 : 1;
  logic [HASH_BITS-1:0] idx;
  logic [7:0]           tbl_byte;

  assign idx = crc[CRC_W-1 -: HASH_BITS];

  generate
    if (HASH_BITS > 3) begin : g_bytewise
      logic [SEL_BITS-1:0] byte_sel;
      assign byte_sel = idx[HASH_BITS-1 -: SEL_BITS];
      assign tbl_byte = table_bits[8*byte_sel +: 8];
      assign hit      = tbl_byte[idx[2:0]];
    end else begin : g_flat
      assign tbl_byte = '0;
      assign hit      = table_bits[idx];
    end
  endgenerate
endmodule

// File: rtl/eaf_filter.sv
module eaf_filter
  import eaf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_BITS  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      byte_vld,
  input  logic                      sof,
  input  logic [7:0]                byte_in,
  input  logic [8*ADDR_BYTES-1:0]   station_addr,
  input  logic [(1<<HASH_BITS)-1:0] hash_tbl,
  input  logic                      promisc,
  input  logic                      all_mcast,
  output logic                      dec_valid,
  output logic                      keep,
  output logic                      is_bcast,
  output logic                      is_mcast
);
  logic             take, first, last, match_upd, ones_upd, group_upd, hit;
  logic [CRC_W-1:0] crc_upd;
  logic             dv_q, keep_q, bc_q, mc_q;
  logic             dv_d, keep_d, bc_d, mc_d;

  eaf_addr_track #(.ADDR_BYTES(ADDR_BYTES)) u_track (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof), .byte_in(byte_in),
    .station_addr(station_addr), .take(take), .first(first), .last(last),
    .match_upd(match_upd), .ones_upd(ones_upd), .group_upd(group_upd));

  eaf_crc u_crc (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first), .data(byte_in),
    .crc_upd(crc_upd));

  eaf_hash_lookup #(.HASH_BITS(HASH_BITS)) u_hash (
    .crc(crc_upd), .table_bits(hash_tbl), .hit(hit));

  always_comb begin
    dv_d   = dv_q;
    keep_d = keep_q;
    bc_d   = bc_q;
    mc_d   = mc_q;
    if (take && last) begin
      dv_d   = 1'b1;
      bc_d   = ones_upd;
      mc_d   = group_upd & ~ones_upd;
      keep_d = promisc | ones_upd | match_upd | (group_upd & (all_mcast | hit));
    end else if (byte_vld && sof) begin
      dv_d   = 1'b0;
      keep_d = 1'b0;
      bc_d   = 1'b0;
      mc_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q   <= 1'b0;
      keep_q <= 1'b0;
      bc_q   <= 1'b0;
      mc_q   <= 1'b0;
    end else begin
      dv_q   <= dv_d;
      keep_q <= keep_d;
      bc_q   <= bc_d;
      mc_q   <= mc_d;
    end
  end

  assign dec_valid = dv_q;
  assign keep      = keep_q;
  assign is_bcast  = bc_q;
  assign is_mcast  = mc_q;

  // R2: a decision holds until a new frame begins
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_q && !(byte_vld && sof)) |=> (dv_q && $stable(keep_q) && $stable(bc_q) && $stable(mc_q)));
  // R9: promiscuous mode keeps the frame being decided
  assert_promisc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last && promisc) |=> (dv_q && keep_q));
  // R7: all-groups mode keeps any group destination
  assert_allmc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last && group_upd && all_mcast) |=> keep_q);
  // R3: broadcast is kept and never reported as multicast
  assert_bcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_q && bc_q) |-> (keep_q && !mc_q));
endmodule

// File: tb/test_eaf_filter.sv
module test_eaf_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_vld, sof;
  logic [7:0]  byte_in;
  logic [47:0] station_addr;
  logic [63:0] hash_tbl;
  logic        promisc, all_mcast;
  logic        dec_valid, keep, is_bcast, is_mcast;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  eaf_filter i_eaf_filter (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof), .byte_in(byte_in),
    .station_addr(station_addr), .hash_tbl(hash_tbl), .promisc(promisc),
    .all_mcast(all_mcast), .dec_valid(dec_valid), .keep(keep),
    .is_bcast(is_bcast), .is_mcast(is_mcast));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] bin_of(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d = a[47-8*i -: 8];
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ d[b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c[31:26];
  endfunction

  // Drive n bytes of a, first with sof; returns at the negedge after the last edge.
  task automatic send(input logic [47:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld = 1'b1;
      sof      = (i == 0);
      byte_in  = a[47-8*i -: 8];
    end
    @(negedge clk);
    byte_vld = 1'b0;
    sof      = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 dec_valid", dec_valid, 1'b0);
    chk("R1 keep", keep, 1'b0);
    @(negedge clk); byte_vld = 1'b1; byte_in = 8'hFF;
    repeat (7) @(negedge clk);
    byte_vld = 1'b0;
    chk("R1 no frame without sof", dec_valid, 1'b0);
  endtask

  task automatic t_station;
    send(48'h02_11_22_33_44_55, 6);
    chk("R2 valid after byte 5", dec_valid, 1'b1);
    chk("R4 station match kept", keep, 1'b1);
    chk("R6 unicast mcast flag", is_mcast, 1'b0);
    chk("R3 unicast bcast flag", is_bcast, 1'b0);
  endtask

  task automatic t_mismatch;
    send(48'h02_11_22_33_44_56, 6);
    chk("R5 last byte differs", keep, 1'b0);
    send(48'h55_44_33_22_11_02, 6);
    chk("R4 reversed order rejected", keep, 1'b0);
  endtask

  task automatic t_bcast;
    send(48'hFF_FF_FF_FF_FF_FF, 6);
    chk("R3 broadcast kept", keep, 1'b1);
    chk("R3 bcast flag", is_bcast, 1'b1);
    chk("R3 no mcast flag", is_mcast, 1'b0);
  endtask

  task automatic t_hash(input logic [47:0] a);
    logic [5:0] h = bin_of(a);
    hash_tbl = '0;
    send(a, 6);
    chk("R6 mcast flag", is_mcast, 1'b1);
    chk("R8 empty table rejects", keep, 1'b0);
    hash_tbl = 64'd1 << h;
    send(a, 6);
    chk("R8 own bin kept", keep, 1'b1);
    hash_tbl = ~(64'd1 << h);
    send(a, 6);
    chk("R8 other bins reject", keep, 1'b0);
    hash_tbl = '0;
  endtask

  task automatic t_allmc;
    all_mcast = 1'b1;
    send(48'h33_33_00_00_00_FB, 6);
    chk("R7 all groups kept", keep, 1'b1);
    send(48'h02_00_00_00_00_09, 6);
    chk("R7 unicast not covered", keep, 1'b0);
    all_mcast = 1'b0;
  endtask

  task automatic t_promisc;
    promisc = 1'b1;
    send(48'h0A_0B_0C_0D_0E_0F, 6);
    chk("R9 promiscuous keeps", keep, 1'b1);
    promisc = 1'b0;
  endtask

  task automatic t_hold;
    send(48'h02_99_99_99_99_99, 6);
    chk("R5 stranger rejected", keep, 1'b0);
    promisc = 1'b1;
    all_mcast = 1'b1;
    station_addr = 48'h02_99_99_99_99_99;
    hash_tbl = '1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); byte_vld = 1'b1; byte_in = 8'hFF;
    end
    @(negedge clk); byte_vld = 1'b0;
    chk("R10 trailing bytes ignored", keep, 1'b0);
    chk("R10 still valid", dec_valid, 1'b1);
    chk("R10 bcast unchanged", is_bcast, 1'b0);
    promisc = 1'b0; all_mcast = 1'b0; hash_tbl = '0;
    station_addr = 48'h02_11_22_33_44_55;
  endtask

  task automatic t_restart;
    send(48'hFF_FF_FF_FF_FF_FF, 3);
    chk("R2 cleared by frame start", dec_valid, 1'b0);
    send(48'h02_11_22_33_44_57, 5);
    chk("R11 not valid before byte 5", dec_valid, 1'b0);
    send(48'h02_11_22_33_44_57, 6);
    chk("R11 new frame judged alone", keep, 1'b0);
    chk("R11 no broadcast carry-over", is_bcast, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; byte_vld = 1'b0; sof = 1'b0; byte_in = '0;
    station_addr = 48'h02_11_22_33_44_55; hash_tbl = '0;
    promisc = 1'b0; all_mcast = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_station;
    t_mismatch;
    t_bcast;
    t_hash(48'h01_00_5E_00_00_01);
    t_hash(48'h33_33_FF_12_34_56);
    t_allmc;
    t_promisc;
    t_hold;
    t_restart;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule